// File: doc/BRIEF.md
# Valve Instruction Executor

This block carries out one instruction at a time for a single port valve that sits between a processing unit and a packet fabric. It owns a word-wide data latch. An instruction arrives from the instruction ring through a valid/ready handshake and takes one of two forms.

- A literal instruction loads a sign-extended constant into the latch.
- A normal instruction carries per-instruction flags. Depending on those flags, the block waits for an inbound packet, optionally copies its data into the latch, and then sends a data packet, a token packet, or both, to the fabric.

The block raises a one-cycle completion pulse when the instruction has retired, and the ring uses that pulse to apply its repeat and requeue rules. An error flag accompanies the pulse when the flag combination is illegal.

A packet is `1 + PATH_W + WORD_W` bits wide, by default 49 bits:

| Bits | Default | Contents |
|------|---------|----------|
| top bit | bit 48 | token flag |
| next PATH_W bits | bits 47..37 | route |
| low WORD_W bits | bits 36..0 | data word |

The parameter `PORT_KIND` selects the valve type: 0 for an inbox, 1 for an outbox. On an outbox, an instruction that sends data together with an effective token becomes a single data packet whose route comes from the upper bits of the latch.

Top module: `valve_exec`

## Requirements
- R1: After reset `ins_ready`=1, while `in_ready`, `out_valid`, `done` and `err` are all 0 and `data_word` is 0.
- R2: A literal instruction (`ins_literal`=1) sign-extends `ins_lit_value` (its top bit is the sign) to WORD_W bits and loads it into `data_word`. `done` is 1 in the cycle after acceptance, and no packet handshake takes place.
- R3: When `ins_wait_tok` or `ins_wait_dat` is set, `in_ready` is 1 from the cycle after acceptance until one inbound packet is taken. `done` stays 0 until that handshake has occurred.
- R4: When capture is set, an inbound packet with token bit 0 loads its bits WORD_W-1..0 into `data_word`.
- R5: An inbound packet with the token bit (top bit) set never changes `data_word`, even when capture is requested.
- R6: A data send produces `out_pkt` = {0, `ins_dest`, `data_word`}, and the latch value used is the one after any capture by the same instruction.
- R7: A token send produces `out_pkt` = {1, `ins_dest`, zeros}.
- R8: With `ins_tok_last`=1, the token send happens only when `ins_count` is 0. Otherwise the instruction sends no token.
- R9: On an outbox, `ins_send_dat`=1 together with an effective token yields one data packet whose route field is `data_word`[WORD_W-1 -: PATH_W]. No separate token is sent.
- R10: On an inbox, `ins_send_dat`=1 together with an effective token yields the data packet first and then the token packet.
- R11: The following combinations are illegal:
  - waiting for a token and for data at once, on an inbox;
  - capture without waiting for data;
  - `ins_tok_last` without `ins_send_tok`.

  An illegal instruction gives `done`=1 and `err`=1 in the cycle after acceptance, with no handshake and `data_word` unchanged.
- R12: While `out_valid`=1 and `out_ready`=0, `out_pkt` holds steady. `done` follows one cycle after the last outbound handshake.
- R13: `ins_ready` is 0 from acceptance until `done`, and it returns to 1 in the cycle after `done`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low synchronous reset |
| ins_valid | input | 1 | instruction offered by the ring |
| ins_ready | output | 1 | executor idle, instruction taken |
| ins_literal | input | 1 | instruction is a literal load |
| ins_lit_value | input | LIT_W | literal constant, sign in the top bit |
| ins_wait_tok | input | 1 | wait for a token |
| ins_wait_dat | input | 1 | wait for a datum |
| ins_capture | input | 1 | latch the received datum |
| ins_send_dat | input | 1 | send a data packet |
| ins_send_tok | input | 1 | send a token |
| ins_tok_last | input | 1 | token only when count is zero |
| ins_count | input | CNT_W | iteration count of the instruction |
| ins_dest | input | PATH_W | route for outgoing packets |
| in_valid | input | 1 | inbound packet offered |
| in_ready | output | 1 | inbound packet accepted |
| in_pkt | input | 1+PATH_W+WORD_W | inbound packet |
| out_valid | output | 1 | outbound packet offered |
| out_ready | input | 1 | fabric accepts outbound packet |
| out_pkt | output | 1+PATH_W+WORD_W | outbound packet |
| data_word | output | WORD_W | data latch contents |
| done | output | 1 | instruction retired (one-cycle pulse) |
| err | output | 1 | illegal flags, valid with done |

## Verification
Timing is counted in cycles from the clock edge that accepts the instruction.

| Result | Due |
|--------|-----|
| literal load, illegal-instruction retirement | the cycle after that edge |
| `in_ready`, first outbound packet | the cycle after that edge |
| `done` | one cycle after the final handshake |
| inbox token (after its data packet) | one cycle after the data packet's handshake |

Each scenario drives inputs on the falling edge and then steps exactly one rising edge before it reads the outputs at the next falling edge. Every expected value is therefore compared in the single cycle in which the requirement places it. Where a wait is involved, the bench deliberately holds off `in_valid` or `out_ready` for an extra cycle to show that the block stalls rather than completing early.

// File: rtl/valve_pkg.sv
package valve_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WAIT,
        ST_SEND_D,
        ST_SEND_T,
        ST_DONE
    } vstate_e;

    typedef struct packed {
        logic wait_tok;
        logic wait_dat;
        logic capture;
        logic send_dat;
        logic send_tok;
        logic tok_last;
    } vflags_t;

    typedef struct packed {
        logic bad;
        logic need_in;
        logic send_dat;
        logic send_tok;
        logic path_from_data;
    } vplan_t;

endpackage

// File: rtl/valve_decode.sv
module valve_decode
    import valve_pkg::*;
#(
    parameter int CNT_W     = 7,
    parameter bit IS_OUTBOX = 1'b1
) (
    input  vflags_t            flags,
    input  logic [CNT_W-1:0]   count,
    output vplan_t             plan
);

    logic tok_eff;
    logic merged;

    always_comb begin
        tok_eff = flags.send_tok && (!flags.tok_last || (count == '0));
        merged  = IS_OUTBOX && flags.send_dat && tok_eff;

        plan.bad = (!IS_OUTBOX && flags.wait_tok && flags.wait_dat)
                 || (!flags.wait_dat && flags.capture)
                 || (!flags.send_tok && flags.tok_last);
        plan.need_in        = flags.wait_tok || flags.wait_dat;
        plan.send_dat       = flags.send_dat;
        plan.send_tok       = tok_eff && !merged;
        plan.path_from_data = merged;
    end

endmodule

// File: rtl/valve_sext.sv
module valve_sext #(
    parameter int IN_W  = 19,
    parameter int OUT_W = 37
) (
    input  logic [IN_W-1:0]  value_in,
    output logic [OUT_W-1:0] value_out
);

    generate
        if (OUT_W > IN_W) begin : g_extend
            assign value_out = {{(OUT_W-IN_W){value_in[IN_W-1]}}, value_in};
        end else begin : g_trunc
            assign value_out = value_in[OUT_W-1:0];
        end
    endgenerate

endmodule

// File: rtl/valve_pkt.sv
module valve_pkt #(
    parameter int WORD_W    = 37,
    parameter int PATH_W    = 11,
    parameter bit IS_OUTBOX = 1'b1
) (
    input  logic                       is_token,
    input  logic                       path_from_data,
    input  logic [PATH_W-1:0]          dest,
    input  logic [WORD_W-1:0]          word,
    output logic [PATH_W+WORD_W:0]     pkt
);

    logic [PATH_W-1:0] path;

    generate
        if (IS_OUTBOX) begin : g_outbox
            assign path = path_from_data ? word[WORD_W-1 -: PATH_W] : dest;
        end else begin : g_inbox
            logic unused_sel;
            assign unused_sel = path_from_data;
            assign path       = dest;
        end
    endgenerate

    assign pkt = {is_token, path, is_token ? {WORD_W{1'b0}} : word};

endmodule

// File: rtl/valve_exec.sv
module valve_exec
    import valve_pkg::*;
#(
    parameter int WORD_W    = 37,
    parameter int PATH_W    = 11,
    parameter int LIT_W     = 19,
    parameter int CNT_W     = 7,
    parameter int PORT_KIND = 1
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        ins_valid,
    output logic                        ins_ready,
    input  logic                        ins_literal,
    input  logic [LIT_W-1:0]            ins_lit_value,
    input  logic                        ins_wait_tok,
    input  logic                        ins_wait_dat,
    input  logic                        ins_capture,
    input  logic                        ins_send_dat,
    input  logic                        ins_send_tok,
    input  logic                        ins_tok_last,
    input  logic [CNT_W-1:0]            ins_count,
    input  logic [PATH_W-1:0]           ins_dest,
    input  logic                        in_valid,
    output logic                        in_ready,
    input  logic [PATH_W+WORD_W:0]      in_pkt,
    output logic                        out_valid,
    input  logic                        out_ready,
    output logic [PATH_W+WORD_W:0]      out_pkt,
    output logic [WORD_W-1:0]           data_word,
    output logic                        done,
    output logic                        err
);

    localparam int  PKT_W     = 1 + PATH_W + WORD_W;
    localparam int  TOK_BIT   = PKT_W - 1;
    localparam bit  IS_OUTBOX = (PORT_KIND != 0);

    typedef struct packed {
        vstate_e             st;
        vplan_t              plan;
        logic                capture;
        logic [PATH_W-1:0]   dest;
        logic [WORD_W-1:0]   word;
        logic                err;
    } exec_t;

    exec_t q, d;

    vflags_t           flags_w;
    vplan_t            plan_w;
    logic [WORD_W-1:0] lit_ext;
    logic [PATH_W-1:0] unused_in_path;

    assign unused_in_path = in_pkt[TOK_BIT-1 -: PATH_W];

    assign flags_w = '{wait_tok: ins_wait_tok, wait_dat: ins_wait_dat,
                       capture:  ins_capture,  send_dat: ins_send_dat,
                       send_tok: ins_send_tok, tok_last: ins_tok_last};

    valve_decode #(.CNT_W(CNT_W), .IS_OUTBOX(IS_OUTBOX)) i_decode (
        .flags (flags_w),
        .count (ins_count),
        .plan  (plan_w)
    );

    valve_sext #(.IN_W(LIT_W), .OUT_W(WORD_W)) i_sext (
        .value_in  (ins_lit_value),
        .value_out (lit_ext)
    );

    function automatic vstate_e after_input(vplan_t p);
        if (p.send_dat)      return ST_SEND_D;
        else if (p.send_tok) return ST_SEND_T;
        else                 return ST_DONE;
    endfunction

    always_comb begin
        d = q;
        unique case (q.st)
            ST_IDLE: begin
                if (ins_valid) begin
                    d.dest    = ins_dest;
                    d.capture = ins_capture;
                    d.plan    = plan_w;
                    d.err     = 1'b0;
                    if (ins_literal) begin
                        d.word = lit_ext;
                        d.st   = ST_DONE;
                    end else if (plan_w.bad) begin
                        d.err = 1'b1;
                        d.st  = ST_DONE;
                    end else if (plan_w.need_in) begin
                        d.st = ST_WAIT;
                    end else begin
                        d.st = after_input(plan_w);
                    end
                end
            end
            ST_WAIT: begin
                if (in_valid) begin
                    if (q.capture && !in_pkt[TOK_BIT]) begin
                        d.word = in_pkt[WORD_W-1:0];
                    end
                    d.st = after_input(q.plan);
                end
            end
            ST_SEND_D: begin
                if (out_ready) begin
                    d.st = q.plan.send_tok ? ST_SEND_T : ST_DONE;
                end
            end
            ST_SEND_T: begin
                if (out_ready) begin
                    d.st = ST_DONE;
                end
            end
            ST_DONE: begin
                d.st  = ST_IDLE;
                d.err = 1'b0;
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '{st: ST_IDLE, plan: '0, capture: 1'b0,
                   dest: '0, word: '0, err: 1'b0};
        end else begin
            q <= d;
        end
    end

    assign ins_ready = (q.st == ST_IDLE);
    assign in_ready  = (q.st == ST_WAIT);
    assign out_valid = (q.st == ST_SEND_D) || (q.st == ST_SEND_T);
    assign done      = (q.st == ST_DONE);
    assign err       = (q.st == ST_DONE) && q.err;
    assign data_word = q.word;

    valve_pkt #(.WORD_W(WORD_W), .PATH_W(PATH_W), .IS_OUTBOX(IS_OUTBOX)) i_pkt (
        .is_token       (q.st == ST_SEND_T),
        .path_from_data (q.plan.path_from_data),
        .dest           (q.dest),
        .word           (q.word),
        .pkt            (out_pkt)
    );

endmodule

// File: rtl/valve_exec_chk.sv
module valve_exec_chk #(
    parameter int WORD_W = 37,
    parameter int PATH_W = 11
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   ins_valid,
    input logic                   ins_ready,
    input logic                   in_valid,
    input logic                   in_ready,
    input logic [PATH_W+WORD_W:0] in_pkt,
    input logic                   out_valid,
    input logic                   out_ready,
    input logic [PATH_W+WORD_W:0] out_pkt,
    input logic [WORD_W-1:0]      data_word,
    input logic                   done,
    input logic                   err
);

    localparam int TOK_BIT = PATH_W + WORD_W;

    a_r12_out_held: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_pkt));

    a_r7_token_empty: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_pkt[TOK_BIT] |-> out_pkt[WORD_W-1:0] == '0);

    a_r5_token_keeps_word: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready && in_pkt[TOK_BIT] |=> $stable(data_word));

    a_r11_err_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> done && !out_valid && !in_ready);

    a_r3_wait_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |-> !out_valid && !ins_ready && !done);

    a_r13_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        ins_valid && ins_ready |=> !ins_ready);

    a_r13_idle_after_done: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> ins_ready && !done);

endmodule

bind valve_exec valve_exec_chk #(.WORD_W(WORD_W), .PATH_W(PATH_W)) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ins_valid (ins_valid),
    .ins_ready (ins_ready),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_pkt    (in_pkt),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_pkt   (out_pkt),
    .data_word (data_word),
    .done      (done),
    .err       (err)
);

// File: tb/test_valve_exec.sv
`timescale 1ns/1ps
module test_valve_exec;

    localparam int WORD_W = 37;
    localparam int PATH_W = 11;
    localparam int LIT_W  = 19;
    localparam int CNT_W  = 7;
    localparam int PKT_W  = 1 + PATH_W + WORD_W;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    logic              ins_valid = 0, ins_literal = 0;
    logic [LIT_W-1:0]  ins_lit_value = '0;
    logic              ins_wait_tok = 0, ins_wait_dat = 0, ins_capture = 0;
    logic              ins_send_dat = 0, ins_send_tok = 0, ins_tok_last = 0;
    logic [CNT_W-1:0]  ins_count = '0;
    logic [PATH_W-1:0] ins_dest = '0;
    logic              in_valid = 0, out_ready = 0;
    logic [PKT_W-1:0]  in_pkt = '0;

    logic              ins_ready, in_ready, out_valid, done, err;
    logic [PKT_W-1:0]  out_pkt;
    logic [WORD_W-1:0] data_word;
    logic              ins_ready_b, in_ready_b, out_valid_b, done_b, err_b;
    logic [PKT_W-1:0]  out_pkt_b;
    logic [WORD_W-1:0] data_word_b;

    valve_exec #(.WORD_W(WORD_W), .PATH_W(PATH_W), .LIT_W(LIT_W),
                 .CNT_W(CNT_W), .PORT_KIND(1)) i_valve_exec (
        .clk(clk), .rst_n(rst_n), .ins_valid(ins_valid), .ins_ready(ins_ready),
        .ins_literal(ins_literal), .ins_lit_value(ins_lit_value),
        .ins_wait_tok(ins_wait_tok), .ins_wait_dat(ins_wait_dat),
        .ins_capture(ins_capture), .ins_send_dat(ins_send_dat),
        .ins_send_tok(ins_send_tok), .ins_tok_last(ins_tok_last),
        .ins_count(ins_count), .ins_dest(ins_dest),
        .in_valid(in_valid), .in_ready(in_ready), .in_pkt(in_pkt),
        .out_valid(out_valid), .out_ready(out_ready), .out_pkt(out_pkt),
        .data_word(data_word), .done(done), .err(err));

    valve_exec #(.WORD_W(WORD_W), .PATH_W(PATH_W), .LIT_W(LIT_W),
                 .CNT_W(CNT_W), .PORT_KIND(0)) i_valve_exec_ib (
        .clk(clk), .rst_n(rst_n), .ins_valid(ins_valid), .ins_ready(ins_ready_b),
        .ins_literal(ins_literal), .ins_lit_value(ins_lit_value),
        .ins_wait_tok(ins_wait_tok), .ins_wait_dat(ins_wait_dat),
        .ins_capture(ins_capture), .ins_send_dat(ins_send_dat),
        .ins_send_tok(ins_send_tok), .ins_tok_last(ins_tok_last),
        .ins_count(ins_count), .ins_dest(ins_dest),
        .in_valid(in_valid), .in_ready(in_ready_b), .in_pkt(in_pkt),
        .out_valid(out_valid_b), .out_ready(out_ready), .out_pkt(out_pkt_b),
        .data_word(data_word_b), .done(done_b), .err(err_b));

    int n_checks = 0;
    int n_fail   = 0;
    logic [WORD_W-1:0] exp_word = '0;

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic clear_ins();
        ins_literal = 0; ins_lit_value = '0;
        ins_wait_tok = 0; ins_wait_dat = 0; ins_capture = 0;
        ins_send_dat = 0; ins_send_tok = 0; ins_tok_last = 0;
        ins_count = '0; ins_dest = '0;
    endtask

    // Call at a falling edge; returns at the falling edge after acceptance.
    task automatic issue();
        ins_valid = 1;
        @(posedge clk);
        @(negedge clk);
        ins_valid = 0;
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic t_reset();
        chk("R1 ins_ready", 64'(ins_ready), 64'd1);
        chk("R1 in_ready", 64'(in_ready), 64'd0);
        chk("R1 out_valid", 64'(out_valid), 64'd0);
        chk("R1 done/err", 64'({done, err}), 64'd0);
        chk("R1 data_word", 64'(data_word), 64'd0);
    endtask

    task automatic t_literal();
        clear_ins(); ins_literal = 1; ins_lit_value = 19'h40005;
        issue();
        chk("R2 negative literal", 64'(data_word), 64'({{18{1'b1}}, 19'h40005}));
        chk("R2 done next cycle", 64'({done, err, out_valid, in_ready}), 64'b1000);
        chk("R13 busy during done", 64'(ins_ready), 64'd0);
        step();
        chk("R13 ready after done", 64'({ins_ready, done}), 64'b10);
        ins_lit_value = 19'h12345;
        issue();
        exp_word = 37'h0_0001_2345;
        chk("R2 positive literal", 64'(data_word), 64'(exp_word));
        step();
    endtask

    task automatic t_capture();
        clear_ins(); ins_wait_dat = 1; ins_capture = 1;
        issue();
        chk("R3 waiting", 64'({in_ready, done}), 64'b10);
        step();
        chk("R3 still waiting", 64'({in_ready, done}), 64'b10);
        in_pkt = {1'b0, 11'h7FF, 37'h1_2345_6789};
        in_valid = 1;
        step();
        in_valid = 0;
        exp_word = 37'h1_2345_6789;
        chk("R4 captured word", 64'(data_word), 64'(exp_word));
        chk("R3 done after input", 64'({done, in_ready}), 64'b10);
        step();
    endtask

    task automatic t_token_in();
        clear_ins(); ins_wait_dat = 1; ins_capture = 1;
        issue();
        in_pkt = {1'b1, 11'h001, 37'h0_DEAD_BEEF};
        in_valid = 1;
        step();
        in_valid = 0;
        chk("R5 token leaves latch", 64'(data_word), 64'(exp_word));
        chk("R5 retired", 64'(done), 64'd1);
        step();
    endtask

    task automatic t_emit_data();
        clear_ins(); ins_send_dat = 1; ins_dest = 11'h2A5;
        issue();
        chk("R6 data packet", 64'(out_pkt), 64'({1'b0, 11'h2A5, exp_word}));
        chk("R6 out_valid", 64'({out_valid, done}), 64'b10);
        step();
        chk("R12 held under backpressure", 64'(out_pkt), 64'({1'b0, 11'h2A5, exp_word}));
        chk("R12 no early done", 64'({out_valid, done}), 64'b10);
        out_ready = 1;
        step();
        out_ready = 0;
        chk("R12 done after handshake", 64'({done, out_valid}), 64'b10);
        step();
    endtask

    task automatic t_emit_token();
        clear_ins(); ins_send_tok = 1; ins_dest = 11'h155;
        issue();
        chk("R7 token packet", 64'(out_pkt), 64'({1'b1, 11'h155, 37'h0}));
        out_ready = 1;
        step();
        out_ready = 0;
        chk("R7 done", 64'(done), 64'd1);
        step();
    endtask

    task automatic t_tok_last();
        clear_ins(); ins_send_tok = 1; ins_tok_last = 1; ins_count = 7'd3; ins_dest = 11'h0F0;
        issue();
        chk("R8 no token when count nonzero", 64'({out_valid, done, err}), 64'b010);
        step();
        ins_count = 7'd0;
        issue();
        chk("R8 token on last iteration", 64'({out_valid, out_pkt}), 64'({1'b1, 1'b1, 11'h0F0, 37'h0}));
        out_ready = 1;
        step();
        out_ready = 0;
        step();
    endtask

    task automatic t_merged();
        clear_ins(); ins_wait_dat = 1; ins_capture = 1;
        issue();
        in_pkt = {1'b0, 11'h000, 11'h3C7, 26'h0123456};
        in_valid = 1;
        step();
        in_valid = 0;
        exp_word = {11'h3C7, 26'h0123456};
        step();
        clear_ins(); ins_send_dat = 1; ins_send_tok = 1; ins_dest = 11'h011;
        out_ready = 1;
        issue();
        chk("R9 outbox route from latch", 64'(out_pkt), 64'({1'b0, 11'h3C7, exp_word}));
        chk("R10 inbox data first", 64'(out_pkt_b), 64'({1'b0, 11'h011, exp_word}));
        step();
        chk("R9 outbox single packet", 64'({done, out_valid}), 64'b10);
        chk("R10 inbox token second", 64'({out_valid_b, out_pkt_b}), 64'({1'b1, 1'b1, 11'h011, 37'h0}));
        step();
        chk("R10 inbox done", 64'(done_b), 64'd1);
        out_ready = 0;
        step();
    endtask

    task automatic t_illegal();
        clear_ins(); ins_capture = 1; ins_send_dat = 1;
        issue();
        chk("R11 capture without data wait", 64'({done, err, out_valid, in_ready}), 64'b1100);
        chk("R11 latch unchanged", 64'(data_word), 64'(exp_word));
        step();
        clear_ins(); ins_tok_last = 1; ins_send_dat = 1;
        issue();
        chk("R11 tok_last without token", 64'({done, err, out_valid}), 64'b110);
        step();
        clear_ins(); ins_wait_tok = 1; ins_wait_dat = 1;
        issue();
        chk("R11 inbox double wait", 64'({done_b, err_b, in_ready_b}), 64'b110);
        chk("R11 outbox double wait legal", 64'({in_ready, err}), 64'b10);
        in_pkt = {1'b1, 11'h000, 37'h0};
        in_valid = 1;
        step();
        in_valid = 0;
        chk("R11 outbox finishes", 64'({done, err}), 64'b10);
        step();
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_literal();
        t_capture();
        t_token_in();
        t_emit_data();
        t_emit_token();
        t_tok_last();
        t_merged();
        t_illegal();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule